// File: doc/BRIEF.md
# Accumulator Move Saturation Limiter

This block sits on the read side of a 56-bit accumulator. When the accumulator is the source of a move, the block returns the value that should reach the destination. The destination is either a 24-bit word or a 48-bit long word. If the accumulator's signed integer portion shows that the value does not fit, the block substitutes the signed full-scale constant of the destination width. Otherwise it forwards the fraction bits unchanged.

The integer portion is set by the current scaling mode, not by the fixed 8-bit extension field. With no scaling it covers bits 55..47. In scale-down mode it covers bits 55..48. In scale-up mode it covers bits 55..46. A value is judged to fit only when every bit of that window equals the others.

The result and a one-cycle limit flag are registered. Both appear on the clock edge that follows the move request.

Top module: `acc_move_limiter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `res_valid`, `sat_hit` and `res_data` are all zero.
- R2: A move sampled with `mv_req` high produces `res_valid` high exactly one clock later. A cycle with `mv_req` low produces `res_valid` low one clock later.
- R3: With `scale_sel` = 2'b00 (no scaling), a move is limited exactly when bits 55..47 of `acc_in` are not all equal. For example, 0x00_800000_000000 is limited.
- R4: With `scale_sel` = 2'b01 (scale down), a move is limited exactly when bits 55..48 are not all equal. For example, 0x00_800000_000000 passes unlimited.
- R5: With `scale_sel` = 2'b10 (scale up), a move is limited exactly when bits 55..46 are not all equal.
- R6: A limited move with bit 55 clear outputs 0x7FFFFF on a word move (`long_sel`=0) and 0x7FFFFF_FFFFFF on a long move (`long_sel`=1).
- R7: A limited move with bit 55 set outputs 0x800000 on a word move and 0x800000_000000 on a long move.
- R8: An unlimited word move puts `acc_in[47:24]` on `res_data[23:0]`. In a word result, `res_data[47:24]` is always zero.
- R9: An unlimited long move puts `acc_in[47:0]` on `res_data[47:0]`.
- R10: `sat_hit` is high for one cycle, together with `res_valid`, for each limited move, and is low otherwise. When no move is requested, `res_data` keeps its previous value.
- R11: `scale_sel` = 2'b11 is treated as no scaling.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mv_req | input | 1 | Move request: accumulator read as a move source this cycle |
| acc_in | input | 56 | Accumulator value |
| scale_sel | input | 2 | Scaling mode: 00 none, 01 down, 10 up, 11 treated as none |
| long_sel | input | 1 | Destination size: 0 = 24-bit word, 1 = 48-bit long word |
| res_valid | output | 1 | Result valid, one cycle after `mv_req` |
| res_data | output | 48 | Limited move data; a word result is right-aligned in bits 23..0 |
| sat_hit | output | 1 | Pulses with `res_valid` when the move was limited |

## Verification
Every result of this block is due on the first rising edge after the move is presented. This covers `res_valid`, `res_data` and `sat_hit`. The bench therefore drives a move on a falling edge and lowers `mv_req` on the next falling edge. At that same falling edge it samples all three outputs, half a period after the register stage has loaded them. The idle checks sample at the falling edge that follows. There they confirm that `sat_hit` has dropped back after a single cycle and that `res_data` is unchanged.

// File: rtl/acc_lim_pkg.sv
package acc_lim_pkg;

  // Scaling mode encoding as seen on scale_sel
  typedef enum logic [1:0] {
    SCL_NONE = 2'b00,
    SCL_DOWN = 2'b01,
    SCL_UP   = 2'b10,
    SCL_RSVD = 2'b11
  } scale_e;

  // Index of each mode inside the per-mode fit vector
  localparam int MODE_NONE = 0;
  localparam int MODE_DOWN = 1;
  localparam int MODE_UP   = 2;
  localparam int NUM_MODES = 3;

endpackage

// File: rtl/acc_lim_window.sv
// Decides, for the active scaling mode, whether the signed integer portion
// of the accumulator holds more than a sign extension.
module acc_lim_window
  import acc_lim_pkg::*;
#(
  parameter int ACC_W  = 56,
  parameter int LONG_W = 48
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [1:0]       scale,
  output logic             over
);

  logic [NUM_MODES-1:0] mixed;

  // Evaluate all three windows in parallel; the mode only picks a result.
  for (genvar m = 0; m < NUM_MODES; m++) begin : g_win
    localparam int LO = (m == MODE_NONE) ? LONG_W - 1 :
                        (m == MODE_DOWN) ? LONG_W     : LONG_W - 2;
    logic [ACC_W-1:LO] seg;
    assign seg      = acc[ACC_W-1:LO];
    assign mixed[m] = !((&seg) || !(|seg));
  end

  always_comb begin
    unique case (scale_e'(scale))
      SCL_DOWN: over = mixed[MODE_DOWN];
      SCL_UP:   over = mixed[MODE_UP];
      default:  over = mixed[MODE_NONE];
    endcase
  end

endmodule

// File: rtl/acc_lim_select.sv
// Chooses between the saturation constant and the pass-through bits.
module acc_lim_select #(
  parameter int WORD_W = 24,
  parameter int LONG_W = 2 * WORD_W
) (
  input  logic [LONG_W-1:0] frac,
  input  logic              sign,
  input  logic              over,
  input  logic              long_sel,
  output logic [LONG_W-1:0] data
);

  localparam int PAD_W = LONG_W - WORD_W;

  logic [WORD_W-1:0] word_pass;
  logic [WORD_W-1:0] word_sat;
  logic [LONG_W-1:0] long_sat;

  assign word_pass = frac[LONG_W-1:PAD_W];
  assign word_sat  = sign ? {1'b1, {(WORD_W-1){1'b0}}}
                          : {1'b0, {(WORD_W-1){1'b1}}};
  assign long_sat  = sign ? {1'b1, {(LONG_W-1){1'b0}}}
                          : {1'b0, {(LONG_W-1){1'b1}}};

  always_comb begin
    if (long_sel) begin
      data = over ? long_sat : frac;
    end else begin
      data = {{PAD_W{1'b0}}, (over ? word_sat : word_pass)};
    end
  end

endmodule

// File: rtl/acc_lim_reg.sv
// Output register stage: valid and flag every cycle, data on moves only.
module acc_lim_reg #(
  parameter int LONG_W = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [LONG_W-1:0] d_data,
  input  logic              d_lim,
  output logic              q_valid,
  output logic [LONG_W-1:0] q_data,
  output logic              q_lim
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid <= 1'b0;
      q_lim   <= 1'b0;
      q_data  <= '0;
    end else begin
      q_valid <= d_valid;
      q_lim   <= d_valid & d_lim;
      if (d_valid) begin
        q_data <= d_data;
      end
    end
  end

endmodule

// File: rtl/acc_move_limiter.sv
module acc_move_limiter
  import acc_lim_pkg::*;
#(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       mv_req,
  input  logic [2*WORD_W+EXT_W-1:0]  acc_in,
  input  logic [1:0]                 scale_sel,
  input  logic                       long_sel,
  output logic                       res_valid,
  output logic [2*WORD_W-1:0]        res_data,
  output logic                       sat_hit
);

  localparam int LONG_W = 2 * WORD_W;
  localparam int ACC_W  = LONG_W + EXT_W;

  logic              over;
  logic [LONG_W-1:0] sel_data;

  acc_lim_window #(.ACC_W(ACC_W), .LONG_W(LONG_W)) u_window (
    .acc   (acc_in),
    .scale (scale_sel),
    .over  (over)
  );

  acc_lim_select #(.WORD_W(WORD_W), .LONG_W(LONG_W)) u_select (
    .frac     (acc_in[LONG_W-1:0]),
    .sign     (acc_in[ACC_W-1]),
    .over     (over),
    .long_sel (long_sel),
    .data     (sel_data)
  );

  acc_lim_reg #(.LONG_W(LONG_W)) u_reg (
    .clk     (clk),
    .rst     (rst),
    .d_valid (mv_req),
    .d_data  (sel_data),
    .d_lim   (over),
    .q_valid (res_valid),
    .q_data  (res_data),
    .q_lim   (sat_hit)
  );

endmodule

// File: rtl/acc_move_limiter_chk.sv
module acc_move_limiter_chk #(
  parameter int WORD_W = 24,
  parameter int EXT_W  = 8
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      mv_req,
  input logic [2*WORD_W+EXT_W-1:0] acc_in,
  input logic [1:0]                scale_sel,
  input logic                      long_sel,
  input logic                      res_valid,
  input logic [2*WORD_W-1:0]       res_data,
  input logic                      sat_hit
);

  localparam int LONG_W = 2 * WORD_W;
  localparam int ACC_W  = LONG_W + EXT_W;
  localparam logic [LONG_W-1:0] WPOS = {{WORD_W{1'b0}}, 1'b0, {(WORD_W-1){1'b1}}};
  localparam logic [LONG_W-1:0] WNEG = {{WORD_W{1'b0}}, 1'b1, {(WORD_W-1){1'b0}}};
  localparam logic [LONG_W-1:0] LPOS = {1'b0, {(LONG_W-1){1'b1}}};
  localparam logic [LONG_W-1:0] LNEG = {1'b1, {(LONG_W-1){1'b0}}};

  logic [EXT_W-1:0] ext_field;
  assign ext_field = acc_in[ACC_W-1:LONG_W];

  assert_move_answers_R2: assert property (@(posedge clk) disable iff (rst)
    mv_req |=> res_valid);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !mv_req |=> !res_valid);

  assert_flag_with_valid_R10: assert property (@(posedge clk) disable iff (rst)
    sat_hit |-> res_valid);

  assert_idle_holds_data_R10: assert property (@(posedge clk) disable iff (rst)
    !mv_req |=> $stable(res_data));

  // R6 and R7: a limited result is one of the four full-scale constants
  assert_sat_constant_R6: assert property (@(posedge clk) disable iff (rst)
    sat_hit |-> (res_data == WPOS || res_data == WNEG ||
                 res_data == LPOS || res_data == LNEG));

  assert_word_upper_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (mv_req && !long_sel) |=> (res_data[LONG_W-1:WORD_W] == '0));

  assert_down_ext_fits_R4: assert property (@(posedge clk) disable iff (rst)
    (mv_req && scale_sel == 2'b01 && ((&ext_field) || !(|ext_field))) |=> !sat_hit);

endmodule

bind acc_move_limiter acc_move_limiter_chk #(.WORD_W(WORD_W), .EXT_W(EXT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mv_req    (mv_req),
  .acc_in    (acc_in),
  .scale_sel (scale_sel),
  .long_sel  (long_sel),
  .res_valid (res_valid),
  .res_data  (res_data),
  .sat_hit   (sat_hit)
);

// File: tb/tb_acc_move_limiter.sv
module tb_acc_move_limiter;

  logic        clk = 1'b0;
  logic        rst;
  logic        mv_req;
  logic [55:0] acc_in;
  logic [1:0]  scale_sel;
  logic        long_sel;
  logic        res_valid;
  logic [47:0] res_data;
  logic        sat_hit;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  acc_move_limiter dut (
    .clk       (clk),
    .rst       (rst),
    .mv_req    (mv_req),
    .acc_in    (acc_in),
    .scale_sel (scale_sel),
    .long_sel  (long_sel),
    .res_valid (res_valid),
    .res_data  (res_data),
    .sat_hit   (sat_hit)
  );

  task automatic chk(input bit ok, input string tag, input logic [47:0] act,
                     input logic [47:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // Independent model of the requirements
  function automatic bit model_lim(input logic [55:0] a, input logic [1:0] sc);
    int lo;
    lo = (sc == 2'b01) ? 48 : (sc == 2'b10) ? 46 : 47;
    for (int i = lo; i < 55; i++) begin
      if (a[i] != a[55]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [47:0] model_data(input logic [55:0] a,
                                             input logic [1:0] sc, input bit lng);
    if (model_lim(a, sc)) begin
      if (lng) return a[55] ? 48'h800000_000000 : 48'h7FFFFF_FFFFFF;
      else     return a[55] ? 48'h000000_800000 : 48'h000000_7FFFFF;
    end
    return lng ? a[47:0] : {24'h0, a[47:24]};
  endfunction

  // Present one move, then sample on the following falling edge
  task automatic do_move(input logic [55:0] a, input logic [1:0] sc, input bit lng,
                         input string tag);
    logic [47:0] ed;
    bit el;
    ed = model_data(a, sc, lng);
    el = model_lim(a, sc);
    @(negedge clk);
    mv_req = 1'b1; acc_in = a; scale_sel = sc; long_sel = lng;
    @(negedge clk);
    mv_req = 1'b0;
    chk(res_valid == 1'b1, {tag, " valid R2"}, 48'(res_valid), 48'h1);
    chk(res_data == ed, {tag, " data"}, res_data, ed);
    chk(sat_hit == el, {tag, " flag R10"}, 48'(sat_hit), 48'(el));
  endtask

  task automatic test_reset;
    rst = 1'b1; mv_req = 1'b0; acc_in = '0; scale_sel = 2'b00; long_sel = 1'b0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid in reset", 48'(res_valid), 48'h0);
    chk(sat_hit == 1'b0, "R1 flag in reset", 48'(sat_hit), 48'h0);
    chk(res_data == '0, "R1 data in reset", res_data, 48'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0 && sat_hit == 1'b0 && res_data == '0,
        "R1 after reset", res_data, 48'h0);
  endtask

  task automatic test_no_scaling;
    do_move(56'h00_800000_000000, 2'b00, 1'b1, "R3 R6 long pos");
    do_move(56'h00_800000_000000, 2'b00, 1'b0, "R3 R6 word pos");
    do_move(56'h00_7FFFFF_FFFFFF, 2'b00, 1'b1, "R3 R9 fits");
    do_move(56'hFF_800000_000000, 2'b00, 1'b1, "R3 R9 neg fits");
    do_move(56'hFF_7FFFFF_000000, 2'b00, 1'b0, "R3 R7 word neg");
  endtask

  task automatic test_scale_down;
    do_move(56'h00_800000_000000, 2'b01, 1'b0, "R4 R8 fits");
    do_move(56'h01_000000_000000, 2'b01, 1'b1, "R4 R6 long pos");
    do_move(56'hFE_FFFFFF_FFFFFF, 2'b01, 1'b0, "R4 R7 word neg");
  endtask

  task automatic test_scale_up;
    do_move(56'h00_400000_000000, 2'b10, 1'b0, "R5 R6 word pos");
    do_move(56'h00_3FFFFF_123456, 2'b10, 1'b1, "R5 R9 fits");
    do_move(56'hFF_C00000_000001, 2'b10, 1'b0, "R5 R8 neg fits");
    do_move(56'hFF_BFFFFF_FFFFFF, 2'b10, 1'b1, "R5 R7 long neg");
  endtask

  task automatic test_reserved_mode;
    do_move(56'h00_800000_000000, 2'b11, 1'b1, "R11 limits");
    do_move(56'h00_400000_ABCDEF, 2'b11, 1'b0, "R11 R8 fits");
  endtask

  task automatic test_idle_after_limit;
    logic [47:0] held;
    do_move(56'h80_000000_000000, 2'b00, 1'b1, "R10 R7 limited");
    held = res_data;
    acc_in = 56'h00_123456_789ABC; long_sel = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R2 idle valid", 48'(res_valid), 48'h0);
    chk(sat_hit == 1'b0, "R10 flag one cycle", 48'(sat_hit), 48'h0);
    chk(res_data == held, "R10 data held", res_data, held);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    test_reset();
    test_no_scaling();
    test_scale_down();
    test_scale_up();
    test_reserved_mode();
    test_idle_after_limit();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule